// File: doc/BRIEF.md
# Feedback-Driven Switching Clock with Frequency Foldback and Jitter

This block sets the switching rhythm for a peak-current-mode converter controller. Each cycle it emits a one-clock set pulse that starts a power pulse, and a window that bounds how long the switch may stay on. The feedback level arrives as an unsigned millivolt code. When feedback is high the cycle runs at the nominal rate, which is 65 kHz by default and 100 kHz if `NOM_HZ` is changed at build time. As feedback sinks below 1.90 V the period stretches linearly, and from 1.50 V downward the rate holds at a 26 kHz floor.

A triangular offset of five percent of the nominal period, swept at 240 Hz, is added to every period, whether the block is at nominal rate or folded back. Below 1.0 V a flag tells the current comparator to freeze its peak setpoint. Below 0.80 V whole cycles are skipped, and skipping stops only when feedback climbs 30 mV above that level. The period counter keeps running while cycles are skipped, so pulses resume on a period boundary.

Top module: `fold_jitter_clkgen`

## Requirements
- R1: While reset is low, set_o and dmax_o are 0, skip_o is 1 and freeze_o is 0.
- R2: With jitter off and fb_mv >= 1900, set pulses are P_NOM = SYS_HZ/NOM_HZ clocks apart (100 clocks by default).
- R3: With jitter off and fb_mv <= 1500, set pulses are P_MIN = SYS_HZ/MIN_HZ clocks apart (250 by default).
- R4: With jitter off and 1500 < fb_mv < 1900, the period is P_MIN - floor((P_MIN-P_NOM)*(fb_mv-1500)/400).
- R5: dmax_o rises together with set_o and stays high for floor(period*DMAX_PCT/100) clocks, with DMAX_PCT = 80. It is never low while set_o is high.
- R6: With jitter on, each period lies within base ± JA, where JA = floor(P_NOM*JIT_PCT/100). Both extremes are reached within one 240 Hz sweep, at nominal rate and in foldback alike.
- R7: One clock after fb_mv is seen below 800, skip_o is 1. From the next period boundary on, no set pulse appears and dmax_o stays low.
- R8: Once skip_o is 1 it stays 1 while fb_mv < 830 and clears one clock after fb_mv >= 830. A level between 800 and 829 does not start skipping.
- R9: A skipped cycle is dropped whole. The first set pulse after skipping ends lies a whole number of periods after the last set pulse before skipping began.
- R10: freeze_o is 1 one clock after fb_mv < 1000 and 0 one clock after fb_mv >= 1000.
- R11: set_o is high for exactly one clock per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fb_mv | input | FB_W | Feedback level in millivolts, unsigned |
| set_o | output | 1 | One-clock pulse that starts a switching cycle |
| dmax_o | output | 1 | Window during which the switch may be on |
| skip_o | output | 1 | Cycles are being skipped |
| freeze_o | output | 1 | Peak current setpoint frozen |

## Verification
The properties assume that fb_mv is a settled code that changes only between clock edges, and that the period always exceeds one clock, so a set pulse can never be followed by another one cycle later. The stimulus changes feedback only on falling edges and holds each level for several periods before measuring. This means every measured period was latched from a single feedback value. The skip tests step through levels on both sides of the hysteresis band, and only after the previous state has fully settled.

// File: rtl/fold_jitter_clkgen.sv
`timescale 1ns/1ps
module fold_jitter_clkgen #(
  parameter int unsigned SYS_HZ      = 6_500_000,
  parameter int unsigned NOM_HZ      = 65_000,
  parameter int unsigned MIN_HZ      = 26_000,
  parameter int unsigned JIT_PCT     = 5,
  parameter int unsigned JIT_HZ      = 240,
  parameter int unsigned DMAX_PCT    = 80,
  parameter int unsigned FB_W        = 13,
  parameter int unsigned FOLD_HI_MV  = 1900,
  parameter int unsigned FOLD_LO_MV  = 1500,
  parameter int unsigned FREEZE_MV   = 1000,
  parameter int unsigned SKIP_MV     = 800,
  parameter int unsigned SKIP_HYS_MV = 30
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [FB_W-1:0] fb_mv,
  output logic            set_o,
  output logic            dmax_o,
  output logic            skip_o,
  output logic            freeze_o
);
  localparam int unsigned P_NOM   = SYS_HZ / NOM_HZ;
  localparam int unsigned P_MIN   = SYS_HZ / MIN_HZ;
  localparam int unsigned P_SPAN  = P_MIN - P_NOM;
  localparam int unsigned FB_SPAN = FOLD_HI_MV - FOLD_LO_MV;
  localparam int unsigned JA      = P_NOM * JIT_PCT / 100;
  localparam int unsigned PW      = $clog2(P_MIN + JA + 1) + 1;
  localparam int unsigned JSTEP   = (JA == 0) ? 1 : SYS_HZ / (JIT_HZ * 4 * JA);
  localparam int unsigned JSW     = $clog2(JSTEP + 1);

  localparam logic [FB_W-1:0] TH_HI  = FB_W'(FOLD_HI_MV);
  localparam logic [FB_W-1:0] TH_LO  = FB_W'(FOLD_LO_MV);
  localparam logic [FB_W-1:0] TH_FRZ = FB_W'(FREEZE_MV);
  localparam logic [FB_W-1:0] TH_SON = FB_W'(SKIP_MV);
  localparam logic [FB_W-1:0] TH_SOF = FB_W'(SKIP_MV + SKIP_HYS_MV);

  logic [PW-1:0]        cnt, per_q, lim_q, base, per_nxt, lim_nxt;
  logic signed [PW-1:0] jit;
  logic                 cyc_en, skip_q, frz_q;
  logic [31:0]          fold_d;

  assign fold_d = 32'(fb_mv) - FOLD_LO_MV;

  always_comb begin
    if (fb_mv >= TH_HI)      base = PW'(P_NOM);
    else if (fb_mv <= TH_LO) base = PW'(P_MIN);
    else                     base = PW'(P_MIN - (P_SPAN * fold_d) / FB_SPAN);
  end

  generate
    if (JA == 0) begin : g_nojit
      assign jit = '0;
    end else begin : g_jit
      localparam logic signed [PW-1:0] JMAX = PW'(JA);
      localparam logic signed [PW-1:0] ONE  = PW'(1);
      logic [JSW-1:0] pre;
      logic           up;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          pre <= '0;
          jit <= '0;
          up  <= 1'b1;
        end else if (pre == JSW'(JSTEP - 1)) begin
          pre <= '0;
          if (up) begin
            jit <= jit + ONE;
            if (jit + ONE == JMAX) up <= 1'b0;
          end else begin
            jit <= jit - ONE;
            if (jit - ONE == -JMAX) up <= 1'b1;
          end
        end else begin
          pre <= pre + 1'b1;
        end
      end
    end
  endgenerate

  assign per_nxt = base + $unsigned(jit);
  assign lim_nxt = PW'((32'(per_nxt) * DMAX_PCT) / 100);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      per_q  <= PW'(P_NOM);
      lim_q  <= PW'(P_NOM * DMAX_PCT / 100);
      cyc_en <= 1'b0;
      skip_q <= 1'b1;
      frz_q  <= 1'b0;
    end else begin
      skip_q <= skip_q ? (fb_mv < TH_SOF) : (fb_mv < TH_SON);
      frz_q  <= fb_mv < TH_FRZ;
      if (cnt == per_q - 1'b1) begin
        cnt    <= '0;
        per_q  <= per_nxt;
        lim_q  <= lim_nxt;
        cyc_en <= ~skip_q;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign set_o    = cyc_en && (cnt == '0);
  assign dmax_o   = cyc_en && (cnt < lim_q);
  assign skip_o   = skip_q;
  assign freeze_o = frz_q;
endmodule

// File: rtl/fold_jitter_clkgen_chk.sv
`timescale 1ns/1ps
module fold_jitter_clkgen_chk #(
  parameter int unsigned FB_W        = 13,
  parameter int unsigned FREEZE_MV   = 1000,
  parameter int unsigned SKIP_MV     = 800,
  parameter int unsigned SKIP_HYS_MV = 30
) (
  input logic            clk,
  input logic            rst_n,
  input logic [FB_W-1:0] fb_mv,
  input logic            set_o,
  input logic            dmax_o,
  input logic            skip_o,
  input logic            freeze_o
);
  localparam logic [FB_W-1:0] C_FRZ = FB_W'(FREEZE_MV);
  localparam logic [FB_W-1:0] C_SON = FB_W'(SKIP_MV);
  localparam logic [FB_W-1:0] C_SOF = FB_W'(SKIP_MV + SKIP_HYS_MV);

  // R11
  set_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_o |=> !set_o);
  // R5
  set_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_o |-> dmax_o);
  // R7
  skip_blocks_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    skip_o |=> !set_o);
  // R7
  skip_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_mv < C_SON) |=> skip_o);
  // R8
  skip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_o && fb_mv < C_SOF) |=> skip_o);
  // R8
  skip_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_mv >= C_SOF) |=> !skip_o);
  // R10
  freeze_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_mv < C_FRZ) |=> freeze_o);
  // R10
  freeze_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_mv >= C_FRZ) |=> !freeze_o);
endmodule

bind fold_jitter_clkgen fold_jitter_clkgen_chk #(
  .FB_W(FB_W), .FREEZE_MV(FREEZE_MV), .SKIP_MV(SKIP_MV), .SKIP_HYS_MV(SKIP_HYS_MV)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fb_mv(fb_mv), .set_o(set_o),
  .dmax_o(dmax_o), .skip_o(skip_o), .freeze_o(freeze_o)
);

// File: tb/sim_fold_jitter_clkgen.sv
`timescale 1ns/1ps
module sim_fold_jitter_clkgen;
  localparam int P_NOM = 100;
  localparam int P_MIN = 250;
  localparam int JA    = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] fb = 13'd3000;
  logic        set0, dmax0, skip0, frz0;
  logic        set1, dmax1, skip1, frz1;

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  int last1 = 0, per1 = 0, dm1 = 0, dmcnt = 0, nset1 = 0, ndmax1 = 0;
  int last0 = 0, min0 = 0, max0 = 0, oob0 = 0, base0 = 0;
  bit trk0 = 1'b0, done = 1'b0;

  always #10 clk = ~clk;

  fold_jitter_clkgen u0 (.clk(clk), .rst_n(rst_n), .fb_mv(fb),
    .set_o(set0), .dmax_o(dmax0), .skip_o(skip0), .freeze_o(frz0));

  fold_jitter_clkgen #(.JIT_PCT(0)) u1 (.clk(clk), .rst_n(rst_n), .fb_mv(fb),
    .set_o(set1), .dmax_o(dmax1), .skip_o(skip1), .freeze_o(frz1));

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (set1) begin
      per1  <= cyc - last1;
      last1 <= cyc;
      dm1   <= dmcnt;
      dmcnt <= dmax1 ? 1 : 0;
      nset1 <= nset1 + 1;
    end else if (dmax1) begin
      dmcnt <= dmcnt + 1;
    end
    if (dmax1) ndmax1 <= ndmax1 + 1;
    if (set0) begin
      last0 <= cyc;
      if (trk0) begin
        if (cyc - last0 < min0) min0 <= cyc - last0;
        if (cyc - last0 > max0) max0 <= cyc - last0;
        if (cyc - last0 < base0 - JA || cyc - last0 > base0 + JA) oob0 <= oob0 + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_base(input int f);
    if (f >= 1900) return P_NOM;
    if (f <= 1500) return P_MIN;
    return P_MIN - ((P_MIN - P_NOM) * (f - 1500)) / 400;
  endfunction

  task automatic drive(input int v);
    @(negedge clk);
    fb = 13'(v);
  endtask

  task automatic wait_set1();
    @(posedge set1);
    @(posedge clk);
    #1;
  endtask

  task automatic wait_set0();
    @(posedge set0);
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic period_check(input int f);
    int e;
    drive(f);
    wait_set1();
    wait_set1();
    wait_set1();
    e = exp_base(f);
    if (f >= 1900)      chk(per1 == e, "R2", per1, e);
    else if (f <= 1500) chk(per1 == e, "R3", per1, e);
    else                chk(per1 == e, "R4", per1, e);
    chk(dm1 == (e * 80) / 100, "R5", dm1, (e * 80) / 100);
    chk(set1 == 1'b0, "R11", set1, 0);
  endtask

  task automatic jitter_check(input int f);
    drive(f);
    base0 = exp_base(f);
    wait_set0();
    wait_set0();
    wait_set0();
    min0 = 1 << 20;
    max0 = 0;
    oob0 = 0;
    trk0 = 1'b1;
    idle(30000);
    trk0 = 1'b0;
    chk(oob0 == 0, "R6 bounds", oob0, 0);
    chk(min0 == base0 - JA, "R6 min", min0, base0 - JA);
    chk(max0 == base0 + JA, "R6 max", max0, base0 + JA);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int ns, nd, pre;
    idle(8);
    chk(set1 == 1'b0 && set0 == 1'b0, "R1 set", set1, 0);
    chk(dmax1 == 1'b0 && dmax0 == 1'b0, "R1 dmax", dmax1, 0);
    chk(skip1 == 1'b1, "R1 skip", skip1, 1);
    chk(frz1 == 1'b0, "R1 freeze", frz1, 0);
    @(negedge clk);
    rst_n = 1'b1;

    period_check(3000);
    for (int f = 1450; f <= 1950; f += 25) period_check(f);
    period_check(1200);

    jitter_check(3000);
    jitter_check(1400);

    period_check(1200);
    pre = 0;
    drive(799);
    idle(2);
    chk(skip1 == 1'b1, "R7 enter", skip1, 1);
    idle(600);
    pre = last1;
    ns = nset1;
    nd = ndmax1;
    idle(600);
    chk(nset1 == ns, "R7 no set", nset1 - ns, 0);
    chk(ndmax1 == nd, "R7 no dmax", ndmax1 - nd, 0);
    drive(829);
    idle(600);
    chk(skip1 == 1'b1, "R8 hold", skip1, 1);
    chk(nset1 == ns, "R8 still no set", nset1 - ns, 0);
    drive(830);
    idle(2);
    chk(skip1 == 1'b0, "R8 release", skip1, 0);
    wait_set1();
    chk((last1 - pre) > 0 && ((last1 - pre) % P_MIN) == 0, "R9 boundary", (last1 - pre) % P_MIN, 0);
    drive(810);
    ns = nset1;
    idle(600);
    chk(skip1 == 1'b0, "R8 band no entry", skip1, 0);
    chk(nset1 > ns, "R8 pulses continue", nset1 - ns, 2);
    drive(1000);
    idle(1);
    chk(frz1 == 1'b0, "R10 at 1000", frz1, 0);
    drive(999);
    idle(1);
    chk(frz1 == 1'b1, "R10 at 999", frz1, 1);
    drive(1001);
    idle(1);
    chk(frz1 == 1'b0, "R10 release", frz1, 0);
    finish_run();
  end
endmodule